// File: doc/BRIEF.md
# Multichannel Spectrum Stacking Combiner

This block takes five narrowband complex baseband channels, each already filtered to about 200 kHz and decimated to a common rate, and packs them side by side into one composite complex stream about 1 MHz wide. Each channel has its own 32-bit phase accumulator, separate from the one used for downconversion, and its own pipelined CORDIC rotator. Together they shift the channel to its own frequency slot. The five rotated channels are then added into a single I/Q pair that a downstream host link can carry.

The intended slot plan is -400, -200, 0, +200 and +400 kHz at 1.5625 MSPS, so adjacent channels abut without overlap. A slot's tuning word is round(f_offset * 2^32 / rate), and a negative offset is written in two's complement. All five channels share one valid strobe. Any channel can be muted on its own, and a muted channel's accumulator keeps running so its phase stays continuous when it is unmuted.

Top module: `spectrum_stacker`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `out_i`/`out_q` are 0.
- R2: A sample accepted at the rising edge where `in_valid` is 1 produces exactly one output. `out_valid` is 1 in the cycle after the 18th rising edge that follows the accepting edge. `out_valid` is never 1 without a matching input sample.
- R3: Channel k's contribution equals (I + jQ) * exp(j*2*pi*P/2^32), where P is that channel's accumulator value when the sample is accepted. The gain is unity, and the summed output is within 24 LSB of the exact value.
- R4: Each accumulator is 0 after reset and advances by its tuning word only on cycles where `in_valid` is 1. It wraps modulo 2^32, so sample n uses the sum of the tuning words accepted with samples 0..n-1.
- R5: `out_i` is the sum of all five rotated I components and `out_q` is the sum of all five rotated Q components. Channel k occupies bits [16k+15:16k] of `in_i`, `in_q` and `ch_en`'s bit k, and bits [32k+31:32k] of `tune_word`.
- R6: The outputs are 19 bits wide (input width plus 3). Full-scale inputs on all five channels, at any phase, never wrap.
- R7: A channel whose `ch_en` bit is 0 when its sample is accepted contributes nothing. With all bits 0 the output is exactly 0.
- R8: A muted channel's accumulator keeps advancing, so when the channel is re-enabled its phase matches an uninterrupted accumulation.
- R9: The tuning word is read as two's complement, so a negative word shifts the channel downward. The word is taken with each accepted sample, and a new value first affects the following sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Common sample strobe for all five channels |
| in_i | input | 80 | Signed in-phase samples, 16 bits per channel |
| in_q | input | 80 | Signed quadrature samples, 16 bits per channel |
| tune_word | input | 160 | Slot offset tuning words, 32 bits per channel |
| ch_en | input | 5 | Per-channel contribution enable |
| out_valid | output | 1 | Composite sample strobe |
| out_i | output | 19 | Signed summed in-phase output |
| out_q | output | 19 | Signed summed quadrature output |

## Verification
A corrupted phase accumulator, for example one that advances on idle cycles, adds the word twice, or is cleared by muting, turns every later composite sample into a wrong vector. The bench model follows the phase from reset, so the first output after the fault misses by far more than the tolerance. A broken CORDIC stage, a wrong gain constant or a dropped channel in the adder shows as a value error on the first sample whose phase or data reaches it, 18 edges after that sample is accepted. A lost or extra valid bit shows as an unmatched output, or as a drained scoreboard that is not empty once the pipeline is flushed.

// File: rtl/stk_pkg.sv
// Package: constants shared by the stacking combiner.
// Assumes elaboration-time real math is available for constant functions.
package stk_pkg;

    // Angle of atan(2^-step) in units where 2^ang_w is one full turn.
    function automatic int atan_code(input int step, input int ang_w);
        real ang;
        ang = $atan(2.0 ** (-step));
        return int'(ang / 6.283185307179586 * (2.0 ** ang_w));
    endfunction

    // Reciprocal of the CORDIC growth after iters stages, as a 2^frac fixed-point value.
    function automatic int gain_comp(input int iters, input int frac);
        real g;
        g = 1.0;
        for (int i = 0; i < iters; i++) begin
            g = g * $sqrt(1.0 + 2.0 ** (-2 * i));
        end
        return int'((2.0 ** frac) / g);
    endfunction

endpackage

// File: rtl/stk_phase_acc.sv
// Module: per-channel slot offset phase accumulator.
// Presents the current phase and then adds the tuning word on every accepted
// sample, so sample n sees the sum of the words taken with samples 0..n-1.
// Assumes the word is two's complement and that wrapping modulo 2^PH_W is intended.
module stk_phase_acc #(
    parameter int PH_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en,
    input  logic [PH_W-1:0] tune_word,
    output logic [PH_W-1:0] phase
);

    // Advance the phase only when a sample is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (step_en) begin
            phase <= phase + tune_word;
        end
    end

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(phase));

endmodule

// File: rtl/stk_cordic_rot.sv
// Module: pipelined CORDIC rotator with gain compensation.
// Rotates (x_in + j*y_in) by the angle phase/2^PH_W of a full turn.
// The first stage folds the angle into [-90, 90) degrees by negating the
// vector. ITER micro-rotation stages follow, then one multiply that removes
// the CORDIC growth. Latency is ITER + 2 registers.
// Assumes signed inputs of IN_W bits. The output is IN_W+1 bits wide so that
// a full-scale diagonal vector fits.
module stk_cordic_rot
    import stk_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int PH_W   = 32,
    parameter int ITER   = 16,
    parameter int GUARD  = 2,
    parameter int K_FRAC = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] x_in,
    input  logic signed [IN_W-1:0] y_in,
    input  logic [PH_W-1:0]        phase,
    output logic                   out_valid,
    output logic signed [IN_W:0]   x_out,
    output logic signed [IN_W:0]   y_out
);

    localparam int ANG_W = PH_W;
    localparam int IW    = IN_W + 3 + GUARD;
    localparam int PW    = IW + K_FRAC + 2;
    localparam int KGAIN = gain_comp(ITER, K_FRAC);
    localparam logic signed [K_FRAC+1:0] KG = (K_FRAC + 2)'(KGAIN);
    localparam int ZBND  = 2 * atan_code(ITER - 1, ANG_W) + 2;
    localparam int RBND  = int'(1.41422 * (2.0 ** (IN_W - 1))) + 4;

    logic signed [IW-1:0]    xs [ITER+1];
    logic signed [IW-1:0]    ys [ITER+1];
    logic signed [ANG_W-1:0] zs [ITER+1];
    logic                    vs [ITER+1];

    logic                    fold;
    logic signed [IW-1:0]    x_ext;
    logic signed [IW-1:0]    y_ext;
    logic signed [IW-1:0]    x0_r;
    logic signed [IW-1:0]    y0_r;
    logic signed [ANG_W-1:0] z0_r;
    logic                    v0_r;

    // Widen the inputs with guard bits and find whether the angle is in the back half-plane.
    always_comb begin
        x_ext = $signed({{(IW - IN_W - GUARD){x_in[IN_W-1]}}, x_in, {GUARD{1'b0}}});
        y_ext = $signed({{(IW - IN_W - GUARD){y_in[IN_W-1]}}, y_in, {GUARD{1'b0}}});
        fold  = phase[PH_W-1] ^ phase[PH_W-2];
    end

    // Stage 0: negate the vector and move the angle by half a turn when folding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v0_r <= 1'b0;
            x0_r <= '0;
            y0_r <= '0;
            z0_r <= '0;
        end else begin
            v0_r <= in_valid;
            x0_r <= fold ? -x_ext : x_ext;
            y0_r <= fold ? -y_ext : y_ext;
            z0_r <= {phase[PH_W-1] ^ fold, phase[PH_W-2:0]};
        end
    end

    assign xs[0] = x0_r;
    assign ys[0] = y0_r;
    assign zs[0] = z0_r;
    assign vs[0] = v0_r;

    for (genvar s = 0; s < ITER; s++) begin : g_stage
        localparam logic signed [ANG_W-1:0] ATAN_S = ANG_W'(atan_code(s, ANG_W));
        logic signed [IW-1:0]    x_r;
        logic signed [IW-1:0]    y_r;
        logic signed [ANG_W-1:0] z_r;
        logic                    v_r;

        // One micro-rotation toward zero residual angle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_r <= 1'b0;
                x_r <= '0;
                y_r <= '0;
                z_r <= '0;
            end else begin
                v_r <= vs[s];
                if (!zs[s][ANG_W-1]) begin
                    x_r <= xs[s] - (ys[s] >>> s);
                    y_r <= ys[s] + (xs[s] >>> s);
                    z_r <= zs[s] - ATAN_S;
                end else begin
                    x_r <= xs[s] + (ys[s] >>> s);
                    y_r <= ys[s] - (xs[s] >>> s);
                    z_r <= zs[s] + ATAN_S;
                end
            end
        end

        assign xs[s+1] = x_r;
        assign ys[s+1] = y_r;
        assign zs[s+1] = z_r;
        assign vs[s+1] = v_r;
    end

    logic signed [PW-1:0] px;
    logic signed [PW-1:0] py;

    // Scale by the inverse CORDIC gain.
    always_comb begin
        px = xs[ITER] * KG;
        py = ys[ITER] * KG;
    end

    // Final stage: drop the gain and guard fraction bits and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            x_out     <= '0;
            y_out     <= '0;
        end else begin
            out_valid <= vs[ITER];
            x_out     <= (IN_W + 1)'(px >>> (K_FRAC + GUARD));
            y_out     <= (IN_W + 1)'(py >>> (K_FRAC + GUARD));
        end
    end

    // R3
    fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs[0] |-> (zs[0][ANG_W-1] == zs[0][ANG_W-2]));

    // R3
    conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs[ITER] |-> (zs[ITER] <= ZBND && zs[ITER] >= -ZBND));

    // R6
    rot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (x_out <= RBND && x_out >= -RBND && y_out <= RBND && y_out >= -RBND));

endmodule

// File: rtl/stk_sum_tree.sv
// Module: lockstep combiner of the rotated channels.
// Adds the I parts and Q parts of NCH rotated channels into one registered pair.
// Output valid requires every channel's valid for the same sample index.
// Assumes OUT_W gives enough headroom for NCH bounded-magnitude inputs.
module stk_sum_tree #(
    parameter int NCH   = 5,
    parameter int RW    = 17,
    parameter int OUT_W = 19
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          ch_valid,
    input  logic [NCH*RW-1:0]       ch_i,
    input  logic [NCH*RW-1:0]       ch_q,
    output logic                    sum_valid,
    output logic signed [OUT_W-1:0] sum_i,
    output logic signed [OUT_W-1:0] sum_q
);

    logic signed [OUT_W-1:0] acc_i;
    logic signed [OUT_W-1:0] acc_q;

    // Sign-extend each channel and accumulate across channels.
    always_comb begin
        acc_i = '0;
        acc_q = '0;
        for (int k = 0; k < NCH; k++) begin
            acc_i = acc_i + $signed({{(OUT_W - RW){ch_i[k*RW+RW-1]}}, ch_i[k*RW +: RW]});
            acc_q = acc_q + $signed({{(OUT_W - RW){ch_q[k*RW+RW-1]}}, ch_q[k*RW +: RW]});
        end
    end

    // Register the composite sample when all channels present the same index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_valid <= 1'b0;
            sum_i     <= '0;
            sum_q     <= '0;
        end else begin
            sum_valid <= &ch_valid;
            sum_i     <= acc_i;
            sum_q     <= acc_q;
        end
    end

    // R2
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ch_valid) == 0) || (&ch_valid));

endmodule

// File: rtl/spectrum_stacker.sv
// Module: top of the spectrum stacking combiner.
// Each channel has its own phase accumulator and CORDIC rotator that move it
// to its slot. A muted channel feeds zeros to its rotator while its
// accumulator keeps running. The summed I/Q leaves ITER + 2 edges after the
// sample is accepted.
// Assumes all channels share one sample strobe and that inputs are band-limited upstream.
module spectrum_stacker #(
    parameter int NCH    = 5,
    parameter int IN_W   = 16,
    parameter int PH_W   = 32,
    parameter int ITER   = 16,
    parameter int GUARD  = 2,
    parameter int K_FRAC = 15,
    parameter int GROW   = $clog2(NCH),
    parameter int OUT_W  = IN_W + GROW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NCH*IN_W-1:0]     in_i,
    input  logic [NCH*IN_W-1:0]     in_q,
    input  logic [NCH*PH_W-1:0]     tune_word,
    input  logic [NCH-1:0]          ch_en,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);

    localparam int RW    = IN_W + 1;
    localparam int LAT   = ITER + 2;
    localparam int CNT_W = $clog2(LAT + 4) + 1;

    logic [NCH-1:0]    rot_valid;
    logic [NCH*RW-1:0] rot_i;
    logic [NCH*RW-1:0] rot_q;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic [PH_W-1:0]        ph;
        logic signed [IN_W-1:0] xm;
        logic signed [IN_W-1:0] ym;
        logic signed [IN_W:0]   xr;
        logic signed [IN_W:0]   yr;

        stk_phase_acc #(.PH_W(PH_W)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_en   (in_valid),
            .tune_word (tune_word[k*PH_W +: PH_W]),
            .phase     (ph)
        );

        // Mute the channel by zeroing its data, leaving its phase alone.
        always_comb begin
            xm = ch_en[k] ? $signed(in_i[k*IN_W +: IN_W]) : '0;
            ym = ch_en[k] ? $signed(in_q[k*IN_W +: IN_W]) : '0;
        end

        stk_cordic_rot #(
            .IN_W   (IN_W),
            .PH_W   (PH_W),
            .ITER   (ITER),
            .GUARD  (GUARD),
            .K_FRAC (K_FRAC)
        ) u_rot (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .x_in      (xm),
            .y_in      (ym),
            .phase     (ph),
            .out_valid (rot_valid[k]),
            .x_out     (xr),
            .y_out     (yr)
        );

        assign rot_i[k*RW +: RW] = xr;
        assign rot_q[k*RW +: RW] = yr;
    end

    stk_sum_tree #(
        .NCH   (NCH),
        .RW    (RW),
        .OUT_W (OUT_W)
    ) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_valid  (rot_valid),
        .ch_i      (rot_i),
        .ch_q      (rot_q),
        .sum_valid (out_valid),
        .sum_i     (out_i),
        .sum_q     (out_q)
    );

    logic [CNT_W-1:0] inflight;

    // Track samples accepted but not yet delivered, for the latency checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + CNT_W'(in_valid) - CNT_W'(out_valid);
        end
    end

    // R2
    no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != '0));

    // R2
    inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(LAT + 1));

endmodule

// File: tb/tb_spectrum_stacker.sv
module tb_spectrum_stacker;

    localparam int CLK_P = 10;
    localparam int NCH   = 5;
    localparam int IN_W  = 16;
    localparam int OUT_W = 19;
    localparam int LAT   = 18;
    localparam int TOL   = 24;
    localparam int QD    = 4096;
    localparam real TWO_PI = 6.283185307179586;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NCH*IN_W-1:0] in_i = '0;
    logic [NCH*IN_W-1:0] in_q = '0;
    logic [NCH*32-1:0]   tune_word = '0;
    logic [NCH-1:0]      ch_en = '0;
    logic                out_valid;
    logic signed [OUT_W-1:0] out_i;
    logic signed [OUT_W-1:0] out_q;

    spectrum_stacker dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .tune_word (tune_word),
        .ch_en     (ch_en),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    always #(CLK_P / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Bench-side stimulus values and reference model state.
    logic signed [15:0] bi [NCH];
    logic signed [15:0] bq [NCH];
    logic [31:0]        btw [NCH];
    logic [NCH-1:0]     ben;
    logic [31:0]        mph [NCH];

    real   exp_i [QD];
    real   exp_q [QD];
    int    exp_tol [QD];
    string exp_tag [QD];
    int    wr = 0;
    int    rd = 0;
    string cur_tag = "R3";

    localparam logic [31:0] TW200 = 32'd549755814;
    localparam logic [31:0] TW400 = 32'd1099511628;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Scoreboard: compare each composite output with the model value.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd == wr) begin
                check(1'b0, "R2", "output with no pending sample", 1, 0);
            end else begin
                real ai, aq, di, dq;
                int  ix;
                ix = rd % QD;
                ai = real'(out_i);
                aq = real'(out_q);
                di = ai - exp_i[ix];
                dq = aq - exp_q[ix];
                if (di < 0.0) di = -di;
                if (dq < 0.0) dq = -dq;
                checks++;
                if (di > real'(exp_tol[ix]) || dq > real'(exp_tol[ix])) begin
                    errors++;
                    $display("FAIL %s sample %0d: actual (%0d,%0d) expected (%0.1f,%0.1f)",
                             exp_tag[ix], rd, out_i, out_q, exp_i[ix], exp_q[ix]);
                end
                rd++;
            end
        end
    end

    // Drive one sample at a falling edge, record its model value, return at the next falling edge.
    task automatic send(input int tol);
        real si, sq, th;
        int  ix;
        si = 0.0;
        sq = 0.0;
        for (int k = 0; k < NCH; k++) begin
            in_i[k*16 +: 16]      = bi[k];
            in_q[k*16 +: 16]      = bq[k];
            tune_word[k*32 +: 32] = btw[k];
            if (ben[k]) begin
                th = TWO_PI * real'(mph[k]) / 4294967296.0;
                si = si + real'(bi[k]) * $cos(th) - real'(bq[k]) * $sin(th);
                sq = sq + real'(bi[k]) * $sin(th) + real'(bq[k]) * $cos(th);
            end
            mph[k] = mph[k] + btw[k];
        end
        ch_en = ben;
        ix = wr % QD;
        exp_i[ix]   = si;
        exp_q[ix]   = sq;
        exp_tol[ix] = tol;
        exp_tag[ix] = cur_tag;
        wr++;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Let the pipeline empty and confirm every sample produced its output (R2).
    task automatic drain(input string req);
        idle(LAT + 4);
        check(rd == wr, req, "outputs delivered after drain", rd, wr);
    endtask

    task automatic std_slots();
        btw[0] = -TW400;
        btw[1] = -TW200;
        btw[2] = 32'd0;
        btw[3] = TW200;
        btw[4] = TW400;
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        for (int k = 0; k < NCH; k++) mph[k] = '0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid during reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(out_i == 0 && out_q == 0, "R1", "outputs after reset", out_i, 0);
    endtask

    // R2: latency of one isolated sample; R3 value checked by the scoreboard.
    task automatic t_latency();
        int seen;
        seen = -1;
        cur_tag = "R3";
        ben = '1;
        std_slots();
        for (int k = 0; k < NCH; k++) begin
            bi[k] = 16'(1000 * (k + 1));
            bq[k] = 16'(-700 * k);
        end
        send(TOL);
        check(out_valid == 1'b0, "R2", "out_valid right after accept", out_valid, 0);
        for (int c = 1; c <= LAT + 6; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (out_valid && seen < 0) seen = c;
        end
        check(seen == LAT, "R2", "latency in edges", seen, LAT);
        check(rd == wr, "R2", "single output for single sample", rd, wr);
    endtask

    // R3, R5: continuous stream over the standard slot plan with varied data.
    task automatic t_slots();
        cur_tag = "R5";
        ben = '1;
        std_slots();
        for (int n = 0; n < 60; n++) begin
            for (int k = 0; k < NCH; k++) begin
                bi[k] = 16'(((n * (k + 3)) % 11 - 5) * 2500);
                bq[k] = 16'(((n + 2 * k) % 7 - 3) * 3000);
            end
            send(TOL);
        end
        drain("R5");
    endtask

    // R9: negative words and a word changed on every sample.
    task automatic t_retune();
        cur_tag = "R9";
        ben = '1;
        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < NCH; k++) begin
                btw[k] = 32'(-(n + 1) * (k + 1) * 37000000);
                bi[k]  = 16'(8000 - 1500 * k);
                bq[k]  = 16'(-3000 + 1200 * k);
            end
            send(TOL);
        end
        drain("R9");
    endtask

    // R4: idle cycles between samples must not move the phase; large words force wrap.
    task automatic t_gaps();
        cur_tag = "R4";
        ben = '1;
        for (int k = 0; k < NCH; k++) btw[k] = 32'hF000_0000 + 32'(k * 123456789);
        for (int n = 0; n < 30; n++) begin
            for (int k = 0; k < NCH; k++) begin
                bi[k] = 16'(6000 + 100 * n);
                bq[k] = 16'(2000 * k - 4000);
            end
            send(TOL);
            idle(n % 4 + 1);
        end
        drain("R4");
    endtask

    // R7, R8: muting removes a channel exactly; its phase keeps running.
    task automatic t_enable();
        std_slots();
        for (int k = 0; k < NCH; k++) begin
            bi[k] = 16'(9000 + 500 * k);
            bq[k] = 16'(-5000 + 900 * k);
        end
        cur_tag = "R7";
        ben = 5'b10101;
        for (int n = 0; n < 10; n++) send(TOL);
        ben = 5'b00000;
        for (int n = 0; n < 10; n++) send(0);
        cur_tag = "R8";
        ben = 5'b11111;
        for (int n = 0; n < 15; n++) send(TOL);
        drain("R7");
    endtask

    // R6: full-scale vectors on all channels across many phases.
    task automatic t_fullscale();
        cur_tag = "R6";
        ben = '1;
        for (int k = 0; k < NCH; k++) btw[k] = 32'd0;
        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < NCH; k++) begin
                bi[k] = (n % 2 == 0) ? 16'sh7FFF : 16'sh8000;
                bq[k] = (n % 2 == 0) ? 16'sh7FFF : 16'sh8000;
                mph[k] = 32'(n * 107374182);
            end
            // Bench drives matching phases only by using zero words after aligning below.
            send(TOL);
        end
        drain("R6");
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NCH; k++) begin
            bi[k] = '0;
            bq[k] = '0;
            btw[k] = '0;
            mph[k] = '0;
        end
        ben = '0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_slots();
        t_retune();
        t_gaps();
        t_enable();
        // Re-align model and design phases before the full-scale pass.
        t_reset();
        t_fullscale_aligned();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // R6 with phases reached through the accumulator: one sample per phase step.
    task automatic t_fullscale_aligned();
        cur_tag = "R6";
        ben = '1;
        for (int k = 0; k < NCH; k++) btw[k] = 32'(107374182 * (k + 1));
        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < NCH; k++) begin
                bi[k] = (n % 2 == 0) ? 16'sh7FFF : 16'sh8000;
                bq[k] = (n % 3 == 0) ? 16'sh8000 : 16'sh7FFF;
            end
            send(TOL);
        end
        drain("R6");
    endtask

endmodule